// File: doc/BRIEF.md
# Adapter Slot Configuration Port and Check Scanner

This block sits between a host register port and a shared configuration bus that reaches up to eight adapter slots. Through the host port, software turns board setup mode off, picks one slot with a setup-enable bit and then reads or writes that slot's configuration registers through eight register windows. The configuration bus carries the selected slot number, a register index, read and write strobes and write data. Read data comes back from the slots in the same cycle.

A pulse on `scan_start` makes the block take over the bus and walk every slot in ascending order. Each visit lasts a fixed four cycles. In each visit the block reads register 5. A slot is flagged when the check bit in that byte is low. When a second bit in that byte is also low, the block reads the slot's two status bytes and keeps them. When the walk ends, the block deselects all slots and reports the flagged-slot mask, the 1-based number of the lowest flagged slot, and one of two verdicts: an error was found in a slot, or none was found and the error must go to the default handler.

Top module: `slotcfg_ctrl`

## Requirements
- R1: After reset, the board setup register reads 0x00 and the adapter setup register reads 0x00. `cfg_en`, `cfg_rd`, `cfg_wr`, `scan_busy`, `scan_done`, `chk_any`, `chk_fallback`, `chk_first`, `chk_mask` and `host_rdata` are all 0.
- R2: A host write to address 1 stores bit 3 as the slot enable and bits 2:0 as the slot number, and drops all other bits. Address 1 reads back as {4'b0, enable, slot}, and `cfg_slot` shows the stored slot number.
- R3: `cfg_en` is high only when the adapter enable is set and the board setup register (address 0) holds exactly 0xFF. When `cfg_en` is low, a write to a window produces no `cfg_wr` and a read from a window returns 0xFF.
- R4: With `cfg_en` high, a host access to address 8+i drives `cfg_idx`=i. A write pulses `cfg_wr` with `cfg_wdata` set to the host data. For a read, `host_rdata` shows that slot register's value from the cycle after the read strobe.
- R5: A `scan_start` that is sampled while idle sets `scan_busy` from the next cycle. `scan_done` rises for exactly one cycle 2+4*8 clock edges after the sampling edge, and `scan_busy` falls on that same edge. After the scan, the adapter setup register reads 0x00 and the board register reads 0xFF.
- R6: During a scan, bit k of `chk_mask` is set exactly when bit 7 of register 5 in slot k reads 0.
- R7: The status bytes of slot k (registers 6 and 7) are read and stored in lane k of `chk_stat_lo`/`chk_stat_hi` (bits 8k+7:8k) only when slot k is flagged and bit 6 of its register 5 is 0. In every other case the lane is 0 and no read of register 6 or 7 is issued.
- R8: At done, `chk_first` is the lowest flagged slot index plus one, or 0 when no slot is flagged.
- R9: At done, `chk_any` is 1 when at least one slot is flagged. `chk_fallback` is 1 when no slot is flagged. The two are never equal.
- R10: While `scan_busy` is high, host writes and reads are ignored (no `cfg_wr`, registers unchanged, `host_rdata` held), and a further `scan_start` has no effect.
- R11: Every configuration read during a scan targets the slot that the walk is currently visiting. Slots are visited from 0 up to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 4 | 0 board setup, 1 adapter setup, 8..15 register windows |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| scan_start | input | 1 | Start a check scan |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | One-cycle scan completion pulse |
| chk_mask | output | 8 | Flagged slot mask |
| chk_first | output | 4 | Lowest flagged slot, 1-based, 0 if none |
| chk_any | output | 1 | At least one slot flagged |
| chk_fallback | output | 1 | No slot flagged; send to default handler |
| chk_stat_lo | output | 64 | Register 6 bytes, one lane per slot |
| chk_stat_hi | output | 64 | Register 7 bytes, one lane per slot |
| cfg_slot | output | 3 | Selected slot |
| cfg_en | output | 1 | Slot selection active |
| cfg_idx | output | 3 | Configuration register index |
| cfg_rd | output | 1 | Configuration read strobe |
| cfg_wr | output | 1 | Configuration write strobe |
| cfg_wdata | output | 8 | Configuration write data |
| cfg_rdata | input | 8 | Configuration read data from selected slot |

## Verification
The bench targets the two active-low bits in register 5. It uses a byte with the check bit low but the valid bit high, and a byte with the valid bit low but the check bit high. A design that mixed up the polarities, or that used the valid bit on its own, would store status bytes, or flag slots, that must stay clear. Flags on slot 0 and slot 7 test the 1-based numbering at both ends and the last-slot wrap. An off-by-one there would report the wrong slot or drop the final visit. An adapter write with high garbage bits and window access while board setup is still on test the gating. A design that got these wrong would reach slots it must not reach. A second start pulse and host writes in the middle of a scan must leave both the done timing and the registers unchanged.

// File: rtl/slotcfg_pkg.sv
package slotcfg_pkg;

  // Register indices that the scan walk depends on.
  localparam int unsigned CHK_REG = 5;
  localparam int unsigned STA_REG = 6;
  localparam int unsigned STB_REG = 7;

  // Host addresses of the two setup registers.
  localparam int unsigned ADDR_BOARD = 0;
  localparam int unsigned ADDR_ADAP  = 1;

  typedef enum logic [2:0] {
    SC_IDLE,
    SC_PREP,
    SC_SEL,
    SC_RD5,
    SC_RD6,
    SC_RD7,
    SC_FIN
  } scan_state_e;

  // Lowest set bit position plus one, zero when nothing is set.
  function automatic int first_flagged(input logic [31:0] m, input int n);
    int r;
    r = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (m[i]) r = i + 1;
    end
    return r;
  endfunction

  // A slot is flagged when its check bit reads low.
  function automatic logic is_flagged(input logic [7:0] b, input int chk_bit);
    return ~b[chk_bit];
  endfunction

  // Status bytes are worth reading when flagged and the valid bit is low.
  function automatic logic status_valid(input logic [7:0] b, input int chk_bit,
                                        input int val_bit);
    return ~b[chk_bit] & ~b[val_bit];
  endfunction

endpackage

// File: rtl/slotcfg_host_regs.sv
module slotcfg_host_regs #(
  parameter int unsigned DW     = 8,
  parameter int unsigned SLW    = 3,
  parameter int unsigned IDXW   = 3,
  parameter int unsigned EN_BIT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_wr,
  input  logic            host_rd,
  input  logic [IDXW:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  input  logic            busy,
  input  logic            sc_board_set,
  input  logic            sc_adap_wr,
  input  logic            sc_adap_en,
  input  logic [SLW-1:0]  sc_adap_slot,
  input  logic [DW-1:0]   cfg_rdata,
  output logic            adap_en,
  output logic [SLW-1:0]  adap_slot,
  output logic            win_ok,
  output logic            win_rd,
  output logic            win_wr,
  output logic [IDXW-1:0] win_idx
);
  import slotcfg_pkg::*;

  localparam int unsigned AW = IDXW + 1;

  logic [DW-1:0]  board_q;
  logic           adap_en_q;
  logic [SLW-1:0] adap_slot_q;
  logic [DW-1:0]  rdata_q;
  logic [DW-1:0]  adap_view;

  logic host_ok;
  logic is_win;
  logic is_board;
  logic is_adap;

  assign host_ok  = ~busy;
  assign is_win   = host_addr[AW-1];
  assign is_board = (host_addr == AW'(ADDR_BOARD));
  assign is_adap  = (host_addr == AW'(ADDR_ADAP));
  assign win_ok   = adap_en_q && (board_q == {DW{1'b1}});
  assign win_idx  = host_addr[IDXW-1:0];
  assign win_wr   = host_wr && host_ok && is_win && win_ok;
  assign win_rd   = host_rd && host_ok && is_win && win_ok;

  always_comb begin
    adap_view              = '0;
    adap_view[EN_BIT]      = adap_en_q;
    adap_view[SLW-1:0]     = adap_slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      board_q     <= '0;
      adap_en_q   <= 1'b0;
      adap_slot_q <= '0;
    end else begin
      if (sc_board_set) begin
        board_q <= {DW{1'b1}};
      end else if (host_wr && host_ok && is_board) begin
        board_q <= host_wdata;
      end
      if (sc_adap_wr) begin
        adap_en_q   <= sc_adap_en;
        adap_slot_q <= sc_adap_slot;
      end else if (host_wr && host_ok && is_adap) begin
        adap_en_q   <= host_wdata[EN_BIT];
        adap_slot_q <= host_wdata[SLW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (host_rd && host_ok) begin
      if (is_win)        rdata_q <= win_ok ? cfg_rdata : {DW{1'b1}};
      else if (is_board) rdata_q <= board_q;
      else if (is_adap)  rdata_q <= adap_view;
      else               rdata_q <= '0;
    end
  end

  assign host_rdata = rdata_q;
  assign adap_en    = adap_en_q;
  assign adap_slot  = adap_slot_q;

endmodule

// File: rtl/slotcfg_scanner.sv
module slotcfg_scanner #(
  parameter int unsigned NSLOT   = 8,
  parameter int unsigned DW      = 8,
  parameter int unsigned SLW     = 3,
  parameter int unsigned IDXW    = 3,
  parameter int unsigned FW      = 4,
  parameter int unsigned CHK_BIT = 7,
  parameter int unsigned VAL_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_start,
  input  logic [DW-1:0]     cfg_rdata,
  output logic              busy,
  output logic              sc_board_set,
  output logic              sc_adap_wr,
  output logic              sc_adap_en,
  output logic [SLW-1:0]    sc_adap_slot,
  output logic              sc_rd,
  output logic [IDXW-1:0]   sc_idx,
  output logic [SLW-1:0]    slot_idx,
  output logic [NSLOT-1:0]  mask,
  output logic [FW-1:0]     first,
  output logic              any,
  output logic              fallback,
  output logic [NSLOT*DW-1:0] stat_lo,
  output logic [NSLOT*DW-1:0] stat_hi,
  output logic              done
);
  import slotcfg_pkg::*;

  localparam logic [SLW-1:0] LAST = SLW'(NSLOT - 1);

  scan_state_e      state_q;
  logic [SLW-1:0]   slot_q;
  logic             capt_q;
  logic [NSLOT-1:0] mask_q;
  logic [FW-1:0]    first_q;
  logic             any_q;
  logic             fb_q;
  logic             done_q;
  logic             start_ok;
  logic [DW-1:0]    lo_q [NSLOT];
  logic [DW-1:0]    hi_q [NSLOT];

  assign start_ok = (state_q == SC_IDLE) && scan_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
      slot_q  <= '0;
      capt_q  <= 1'b0;
      mask_q  <= '0;
      first_q <= '0;
      any_q   <= 1'b0;
      fb_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SC_IDLE: begin
          if (scan_start) begin
            state_q <= SC_PREP;
            mask_q  <= '0;
            first_q <= '0;
            any_q   <= 1'b0;
            fb_q    <= 1'b0;
          end
        end
        SC_PREP: begin
          slot_q  <= '0;
          state_q <= SC_SEL;
        end
        SC_SEL: state_q <= SC_RD5;
        SC_RD5: begin
          mask_q[slot_q] <= is_flagged(cfg_rdata, CHK_BIT);
          capt_q         <= status_valid(cfg_rdata, CHK_BIT, VAL_BIT);
          state_q        <= SC_RD6;
        end
        SC_RD6: state_q <= SC_RD7;
        SC_RD7: begin
          if (slot_q == LAST) begin
            state_q <= SC_FIN;
          end else begin
            slot_q  <= slot_q + 1'b1;
            state_q <= SC_SEL;
          end
        end
        SC_FIN: begin
          done_q  <= 1'b1;
          any_q   <= |mask_q;
          fb_q    <= ~|mask_q;
          first_q <= FW'(first_flagged(32'(mask_q), NSLOT));
          state_q <= SC_IDLE;
        end
        default: state_q <= SC_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
      end else if (start_ok) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
      end else if (capt_q && (slot_q == SLW'(g))) begin
        if (state_q == SC_RD6) lo_q[g] <= cfg_rdata;
        if (state_q == SC_RD7) hi_q[g] <= cfg_rdata;
      end
    end
    assign stat_lo[g*DW +: DW] = lo_q[g];
    assign stat_hi[g*DW +: DW] = hi_q[g];
  end

  always_comb begin
    sc_idx = IDXW'(STB_REG);
    if (state_q == SC_RD5)      sc_idx = IDXW'(CHK_REG);
    else if (state_q == SC_RD6) sc_idx = IDXW'(STA_REG);
  end

  assign busy         = (state_q != SC_IDLE);
  assign sc_board_set = (state_q == SC_PREP);
  assign sc_adap_wr   = (state_q == SC_SEL) || (state_q == SC_FIN);
  assign sc_adap_en   = (state_q == SC_SEL);
  assign sc_adap_slot = (state_q == SC_SEL) ? slot_q : '0;
  assign sc_rd        = (state_q == SC_RD5) ||
                        (((state_q == SC_RD6) || (state_q == SC_RD7)) && capt_q);
  assign slot_idx     = slot_q;
  assign mask         = mask_q;
  assign first        = first_q;
  assign any          = any_q;
  assign fallback     = fb_q;
  assign done         = done_q;

endmodule

// File: rtl/slotcfg_bus_mux.sv
module slotcfg_bus_mux #(
  parameter int unsigned DW   = 8,
  parameter int unsigned IDXW = 3
) (
  input  logic            busy,
  input  logic            win_ok,
  input  logic            win_rd,
  input  logic            win_wr,
  input  logic [IDXW-1:0] win_idx,
  input  logic [DW-1:0]   host_wdata,
  input  logic            sc_rd,
  input  logic [IDXW-1:0] sc_idx,
  output logic            cfg_en,
  output logic            cfg_rd,
  output logic            cfg_wr,
  output logic [IDXW-1:0] cfg_idx,
  output logic [DW-1:0]   cfg_wdata
);
  assign cfg_en    = win_ok;
  assign cfg_rd    = busy ? sc_rd  : win_rd;
  assign cfg_idx   = busy ? sc_idx : win_idx;
  assign cfg_wr    = ~busy & win_wr;
  assign cfg_wdata = host_wdata;
endmodule

// File: rtl/slotcfg_ctrl.sv
module slotcfg_ctrl #(
  parameter int unsigned NSLOT   = 8,
  parameter int unsigned NREG    = 8,
  parameter int unsigned DW      = 8,
  parameter int unsigned EN_BIT  = 3,
  parameter int unsigned CHK_BIT = 7,
  parameter int unsigned VAL_BIT = 6,
  localparam int unsigned SLW    = $clog2(NSLOT),
  localparam int unsigned IDXW   = $clog2(NREG),
  localparam int unsigned FW     = $clog2(NSLOT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [IDXW:0]       host_addr,
  input  logic [DW-1:0]       host_wdata,
  output logic [DW-1:0]       host_rdata,
  input  logic                scan_start,
  output logic                scan_busy,
  output logic                scan_done,
  output logic [NSLOT-1:0]    chk_mask,
  output logic [FW-1:0]       chk_first,
  output logic                chk_any,
  output logic                chk_fallback,
  output logic [NSLOT*DW-1:0] chk_stat_lo,
  output logic [NSLOT*DW-1:0] chk_stat_hi,
  output logic [SLW-1:0]      cfg_slot,
  output logic                cfg_en,
  output logic [IDXW-1:0]     cfg_idx,
  output logic                cfg_rd,
  output logic                cfg_wr,
  output logic [DW-1:0]       cfg_wdata,
  input  logic [DW-1:0]       cfg_rdata
);
  // Named internal events, visible to the bound checker.
  logic            busy;
  logic            sc_board_set;
  logic            sc_adap_wr;
  logic            sc_adap_en;
  logic [SLW-1:0]  sc_adap_slot;
  logic            sc_rd;
  logic [IDXW-1:0] sc_idx;
  logic [SLW-1:0]  scan_slot;
  logic            adap_en;
  logic            win_ok;
  logic            win_rd;
  logic            win_wr;
  logic [IDXW-1:0] win_idx;

  slotcfg_host_regs #(
    .DW(DW), .SLW(SLW), .IDXW(IDXW), .EN_BIT(EN_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy),
    .sc_board_set(sc_board_set), .sc_adap_wr(sc_adap_wr),
    .sc_adap_en(sc_adap_en), .sc_adap_slot(sc_adap_slot),
    .cfg_rdata(cfg_rdata),
    .adap_en(adap_en), .adap_slot(cfg_slot),
    .win_ok(win_ok), .win_rd(win_rd), .win_wr(win_wr), .win_idx(win_idx)
  );

  slotcfg_scanner #(
    .NSLOT(NSLOT), .DW(DW), .SLW(SLW), .IDXW(IDXW), .FW(FW),
    .CHK_BIT(CHK_BIT), .VAL_BIT(VAL_BIT)
  ) u_scan (
    .clk(clk), .rst_n(rst_n),
    .scan_start(scan_start), .cfg_rdata(cfg_rdata),
    .busy(busy),
    .sc_board_set(sc_board_set), .sc_adap_wr(sc_adap_wr),
    .sc_adap_en(sc_adap_en), .sc_adap_slot(sc_adap_slot),
    .sc_rd(sc_rd), .sc_idx(sc_idx), .slot_idx(scan_slot),
    .mask(chk_mask), .first(chk_first), .any(chk_any),
    .fallback(chk_fallback), .stat_lo(chk_stat_lo), .stat_hi(chk_stat_hi),
    .done(scan_done)
  );

  slotcfg_bus_mux #(
    .DW(DW), .IDXW(IDXW)
  ) u_mux (
    .busy(busy), .win_ok(win_ok), .win_rd(win_rd), .win_wr(win_wr),
    .win_idx(win_idx), .host_wdata(host_wdata),
    .sc_rd(sc_rd), .sc_idx(sc_idx),
    .cfg_en(cfg_en), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata)
  );

  assign scan_busy = busy;

endmodule

// File: rtl/slotcfg_checker.sv
module slotcfg_checker #(
  parameter int unsigned NSLOT = 8,
  parameter int unsigned NREG  = 8,
  localparam int unsigned SLW  = $clog2(NSLOT),
  localparam int unsigned IDXW = $clog2(NREG),
  localparam int unsigned FW   = $clog2(NSLOT + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scan_busy,
  input logic            scan_done,
  input logic            chk_any,
  input logic            chk_fallback,
  input logic [FW-1:0]   chk_first,
  input logic            cfg_rd,
  input logic            cfg_wr,
  input logic            cfg_en,
  input logic [IDXW-1:0] cfg_idx,
  input logic [SLW-1:0]  cfg_slot,
  input logic [SLW-1:0]  scan_slot
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) scan_done |=> !scan_done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) scan_done |-> !scan_busy); // R5
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(scan_busy) |-> scan_done); // R5
  AST_READ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) cfg_rd |-> cfg_en); // R3
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) scan_done |-> (chk_any != chk_fallback)); // R9
  AST_FIRST_NONE: assert property (@(posedge clk) disable iff (!rst_n) (scan_done && chk_fallback) |-> (chk_first == '0)); // R8
  AST_FIRST_SOME: assert property (@(posedge clk) disable iff (!rst_n) (scan_done && chk_any) |-> (chk_first != '0)); // R8
  AST_SCAN_IDX: assert property (@(posedge clk) disable iff (!rst_n) (scan_busy && cfg_rd) |-> (cfg_idx >= IDXW'(5))); // R7
  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) scan_busy |-> !cfg_wr); // R10
  AST_SCAN_SLOT: assert property (@(posedge clk) disable iff (!rst_n) (scan_busy && cfg_rd) |-> (cfg_slot == scan_slot)); // R11
endmodule

bind slotcfg_ctrl slotcfg_checker #(
  .NSLOT(NSLOT), .NREG(NREG)
) u_slotcfg_chk (
  .clk(clk), .rst_n(rst_n),
  .scan_busy(scan_busy), .scan_done(scan_done),
  .chk_any(chk_any), .chk_fallback(chk_fallback), .chk_first(chk_first),
  .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
  .cfg_idx(cfg_idx), .cfg_slot(cfg_slot), .scan_slot(scan_slot)
);

// File: tb/slotcfg_ctrl_bench.sv
module slotcfg_ctrl_bench;

  localparam int NS = 8;
  localparam int SCAN_NEG = 2 + 4 * NS + 1; // negedges counted from the start edge

  // {expected mask, reg5 bytes slot7..slot0}
  localparam logic [71:0] VEC [5] = '{
    {8'h00, 64'hFFFF_FFFF_FFFF_FFFF},
    {8'h01, 64'hFFFF_FFFF_FFFF_FF7F},
    {8'h48, 64'hFF00_FFFF_3FFF_FFFF},
    {8'hFF, 64'h3F3F_3F3F_3F3F_3F3F},
    {8'h80, 64'h40FF_FFFF_FFBF_FFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        scan_start = 1'b0;
  logic        scan_busy, scan_done, chk_any, chk_fallback;
  logic [7:0]  chk_mask;
  logic [3:0]  chk_first;
  logic [63:0] chk_stat_lo, chk_stat_hi;
  logic [2:0]  cfg_slot, cfg_idx;
  logic        cfg_en, cfg_rd, cfg_wr;
  logic [7:0]  cfg_wdata, cfg_rdata;

  logic [7:0] sm [NS][8];
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  slotcfg_ctrl u_slotcfg_ctrl (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .scan_start(scan_start), .scan_busy(scan_busy), .scan_done(scan_done),
    .chk_mask(chk_mask), .chk_first(chk_first), .chk_any(chk_any),
    .chk_fallback(chk_fallback), .chk_stat_lo(chk_stat_lo), .chk_stat_hi(chk_stat_hi),
    .cfg_slot(cfg_slot), .cfg_en(cfg_en), .cfg_idx(cfg_idx),
    .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  // Slot model: combinational read, write on the clock edge.
  assign cfg_rdata = sm[cfg_slot][cfg_idx];
  always @(posedge clk) if (cfg_wr) sm[cfg_slot][cfg_idx] <= cfg_wdata;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic run_scan(output int n);
    @(negedge clk);
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
    n = 1;
    while (!scan_done && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int n;
    for (int s = 0; s < NS; s++)
      for (int r = 0; r < 8; r++) sm[s][r] = 8'(16 * s + r);

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(scan_busy), 64'd0);
    chk("R1 done", 64'(scan_done), 64'd0);
    chk("R1 flags", {chk_mask, chk_first, chk_any, chk_fallback}, 64'd0);
    chk("R1 bus", {cfg_en, cfg_rd, cfg_wr}, 64'd0);
    chk("R1 rdata", 64'(host_rdata), 64'd0);
    rst_n = 1'b1;
    hread(4'd0, rd); chk("R1 board reg", 64'(rd), 64'h00);
    hread(4'd1, rd); chk("R1 adapter reg", 64'(rd), 64'h00);

    // R2 slot masking and enable bit
    hwrite(4'd1, 8'hFD);
    hread(4'd1, rd); chk("R2 adapter readback", 64'(rd), 64'h0D);
    chk("R2 cfg_slot", 64'(cfg_slot), 64'd5);

    // R3 board setup still on: window ignored
    chk("R3 cfg_en off", 64'(cfg_en), 64'd0);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 4'd9; host_wdata = 8'h11;
    #0.5;
    chk("R3 no cfg_wr", 64'(cfg_wr), 64'd0);
    @(negedge clk);
    host_wr = 1'b0;
    hread(4'd9, rd); chk("R3 disabled read", 64'(rd), 64'hFF);

    // R4 enable and access slot 5
    hwrite(4'd0, 8'hFF);
    chk("R3 cfg_en on", 64'(cfg_en), 64'd1);
    hread(4'd9, rd); chk("R3 earlier write ignored", 64'(rd), 64'h51);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 4'd10; host_wdata = 8'hA5;
    #0.5;
    chk("R4 cfg_wr/idx/data", {cfg_wr, cfg_idx, cfg_wdata}, {1'b1, 3'd2, 8'hA5});
    @(negedge clk);
    host_wr = 1'b0;
    hread(4'd10, rd); chk("R4 window read", 64'(rd), 64'hA5);
    hwrite(4'd1, 8'h0B);
    hread(4'd12, rd); chk("R4 other slot read", 64'(rd), 64'h34);

    // R6 R7 R8 R9 table of scans
    foreach (VEC[v]) begin
      logic [7:0] emask;
      logic [63:0] elo, ehi;
      int efirst;
      emask = VEC[v][71:64];
      elo = '0; ehi = '0; efirst = 0;
      for (int s = 0; s < NS; s++) begin
        logic [7:0] b;
        b = VEC[v][8*s +: 8];
        sm[s][5] = b;
        sm[s][6] = 8'(8'h60 + s);
        sm[s][7] = 8'(8'h70 + s);
        if (b[7] == 1'b0 && b[6] == 1'b0) begin
          elo[8*s +: 8] = 8'(8'h60 + s);
          ehi[8*s +: 8] = 8'(8'h70 + s);
        end
      end
      for (int s = NS - 1; s >= 0; s--) if (emask[s]) efirst = s + 1;
      run_scan(n);
      chk("R5 done timing", 64'(n), 64'(SCAN_NEG));
      chk("R6 mask", 64'(chk_mask), 64'(emask));
      chk("R7 status lo", chk_stat_lo, elo);
      chk("R7 status hi", chk_stat_hi, ehi);
      chk("R8 first slot", 64'(chk_first), 64'(efirst));
      chk("R9 verdict", {chk_any, chk_fallback}, {emask != 0, emask == 0});
      @(negedge clk);
      chk("R5 done one cycle", 64'(scan_done), 64'd0);
      hread(4'd1, rd); chk("R5 adapter deselected", 64'(rd), 64'h00);
      hread(4'd0, rd); chk("R5 board off", 64'(rd), 64'hFF);
    end

    // R10 host traffic and restart during a scan
    hwrite(4'd1, 8'h0A);
    @(negedge clk);
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
    n = 1;
    repeat (5) begin @(negedge clk); n++; end
    host_wr = 1'b1; host_addr = 4'd0; host_wdata = 8'h00;
    #0.5;
    chk("R10 no cfg_wr while busy", 64'(cfg_wr), 64'd0);
    @(negedge clk); n++;
    host_addr = 4'd1; host_wdata = 8'h0C;
    @(negedge clk); n++;
    host_wr = 1'b0; scan_start = 1'b1;
    @(negedge clk); n++;
    scan_start = 1'b0;
    while (!scan_done && n < 100) begin @(negedge clk); n++; end
    chk("R10 restart ignored timing", 64'(n), 64'(SCAN_NEG));
    hread(4'd0, rd); chk("R10 board unchanged", 64'(rd), 64'hFF);
    hread(4'd1, rd); chk("R10 adapter unchanged", 64'(rd), 64'h00);
    chk("R11 last vector mask kept order", 64'(chk_first), 64'd8);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule